// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of a multi-channel event timer. A shared free-running main counter is fed into the channel. The channel compares that value against its own comparator and raises a one-cycle fire pulse when they meet. In one-shot mode the comparator stays put after a fire. In periodic mode a hidden period register is added to the comparator on every fire, so the channel keeps firing at a fixed spacing.

The global timer block owns address decoding across channels. It asserts a select line for this channel and then uses a 32-bit register port with a small offset to reach a configuration word, a read-only capability word and the two halves of the comparator. In periodic mode, a write to the comparator offset loads the hidden period. A self-clearing set-value bit lets software place the comparator directly instead, which gives it the first expiry. A 32-bit mode limits the comparator and period to their low halves, and the comparison is then made on the low 32 counter bits only.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the configuration word at offset 0x00 reads 0x00000010, the capability word at 0x04 reads 0x000000FF, both comparator halves (0x08 low, 0x0C high) read 0xFFFFFFFF, and fire_o is low.
- R2: A write to 0x00 changes only the bits in mask 0x3F4E: bit 1 level type, bit 2 enable, bit 3 periodic, bit 6 set-value, bit 8 32-bit mode, bits 13:9 route. Every other bit keeps its value, and bit 4 (periodic-capable) stays 1.
- R3: The word at 0x04 always reads 0x000000FF, and writes to it have no effect.
- R4: A comparator write goes to the comparator when periodic (bit 3) is clear or set-value (bit 6) is set. Otherwise it goes to the hidden period. A write to 0x08 loads the zero-extended data. A write to 0x0C replaces the upper half and keeps the lower half of the same target.
- R5: Bit 6 reads 0 after any comparator write (0x08 or 0x0C).
- R6: A configuration write with bit 8 set clears the upper 32 bits of the comparator and of the period. While bit 8 is set, writes to 0x0C leave the upper half at zero, and the comparison uses only counter bits 31:0.
- R7: fire_o is high for exactly the one cycle after a clock edge at which enable (bit 2), glb_en_i and counter==comparator all held. The comparison is 64-bit when bit 8 is clear.
- R8: On that same edge in periodic mode, the comparator becomes comparator + period, truncated to 32 bits in 32-bit mode.
- R9: In one-shot mode the comparator is unchanged by a fire, so a counter that keeps running fires the channel only once.
- R10: Offset 0x10 and any unmapped offset read 0. reg_rdata_o is 0 when reg_sel_i is low, and writes while reg_sel_i is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable from the timer block |
| reg_sel_i | input | 1 | This channel selected for register access |
| reg_wr_i | input | 1 | Write strobe (one write per cycle) |
| reg_addr_i | input | 5 | Byte offset within the channel |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current offset (combinational) |
| fire_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume the counter moves between fires and is not parked on the comparator value. A parked counter would keep the match true, and a one-shot channel would then pulse on every cycle. They also assume one register access per cycle, and that reads of a word are not relied on in the same cycle as a write to it. The stimulus stops the counter only at values that differ from the comparator. It changes every register input half a cycle away from the active edge, and issues at most one write per cycle. This keeps the advance and hold properties free of write collisions, except where a test pairs them on purpose.

// File: rtl/evt_chan_pkg.sv
// Shared constants for the comparator timer channel: register offsets,
// configuration bit positions, write mask and reset values.
// Assumes a 32-bit register port and a 5-bit offset.
package evt_chan_pkg;
    localparam int CH_DW = 32;
    localparam int CH_AW = 5;

    localparam logic [CH_AW-1:0] OFS_CFG    = 5'h00;
    localparam logic [CH_AW-1:0] OFS_CAP    = 5'h04;
    localparam logic [CH_AW-1:0] OFS_CMP_LO = 5'h08;
    localparam logic [CH_AW-1:0] OFS_CMP_HI = 5'h0C;
    localparam logic [CH_AW-1:0] OFS_ROUTE  = 5'h10;

    localparam int B_ENABLE  = 2;
    localparam int B_PERIOD  = 3;
    localparam int B_PERCAP  = 4;
    localparam int B_SIZECAP = 5;
    localparam int B_SETVAL  = 6;
    localparam int B_MODE32  = 8;

    localparam logic [CH_DW-1:0] CFG_WMASK = 32'h0000_3F4E;
    localparam logic [CH_DW-1:0] CFG_RST   = 32'h0000_0010;

    // Decoded view of the mode bits used by the datapath.
    typedef struct packed {
        logic enable;
        logic periodic;
        logic setval;
        logic mode32;
    } chan_mode_t;
endpackage

// File: rtl/evt_chan_cfg.sv
// Configuration word and register write decode for one timer channel.
// Applies the write mask and clears set-value after any comparator write.
// Assumes at most one write per cycle and that the parent gates by select.
module evt_chan_cfg
    import evt_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cfg_o,
    output chan_mode_t    mode_o,
    output logic          cmp_wr_lo_o,
    output logic          cmp_wr_hi_o,
    output logic          trunc_o
);
    logic          wr_hit;
    logic          cfg_wr;
    logic [DW-1:0] cfg_q;

    // Decode which register this cycle's write targets.
    always_comb begin
        wr_hit      = sel_i && wr_i;
        cfg_wr      = wr_hit && (addr_i == OFS_CFG);
        cmp_wr_lo_o = wr_hit && (addr_i == OFS_CMP_LO);
        cmp_wr_hi_o = wr_hit && (addr_i == OFS_CMP_HI);
        trunc_o     = cfg_wr && wdata_i[B_MODE32];
    end

    // Hold the configuration word: masked writes, self-clearing set-value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (cfg_wr) begin
            cfg_q <= (wdata_i & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
        end else if (cmp_wr_lo_o || cmp_wr_hi_o) begin
            cfg_q[B_SETVAL] <= 1'b0;
        end
    end

    // Present the mode bits to the datapath.
    always_comb begin
        cfg_o           = cfg_q;
        mode_o.enable   = cfg_q[B_ENABLE];
        mode_o.periodic = cfg_q[B_PERIOD];
        mode_o.setval   = cfg_q[B_SETVAL];
        mode_o.mode32   = cfg_q[B_MODE32];
    end
endmodule

// File: rtl/evt_chan_cmp.sv
// Comparator and hidden period registers. Steers comparator writes,
// applies 32-bit truncation and advances the comparator on a periodic fire.
// Priority: comparator write, then truncation, then periodic advance.
// Assumes CNT_W - DW <= DW.
module evt_chan_cmp
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    wdata_i,
    input  logic             cmp_wr_lo_i,
    input  logic             cmp_wr_hi_i,
    input  logic             trunc_i,
    input  chan_mode_t       mode_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] per_o
);
    localparam int HI_W = CNT_W - DW;
    localparam logic [CNT_W-1:0] LOW_MASK = {{HI_W{1'b0}}, {DW{1'b1}}};

    logic [CNT_W-1:0] cmp_q, per_q, cmp_d, per_d;
    logic [CNT_W-1:0] tgt, wval, adv;
    logic             to_cmp, any_wr;

    // Work out the steered write value and the periodic reload value.
    always_comb begin
        to_cmp = !mode_i.periodic || mode_i.setval;
        any_wr = cmp_wr_lo_i || cmp_wr_hi_i;
        tgt    = to_cmp ? cmp_q : per_q;
        if (cmp_wr_lo_i)
            wval = {{HI_W{1'b0}}, wdata_i};
        else
            wval = {(mode_i.mode32 ? {HI_W{1'b0}} : wdata_i[HI_W-1:0]), tgt[DW-1:0]};
        adv = cmp_q + per_q;
        if (mode_i.mode32)
            adv = adv & LOW_MASK;
    end

    // Select next comparator and period values by priority.
    always_comb begin
        cmp_d = cmp_q;
        per_d = per_q;
        if (hit_i && mode_i.periodic)
            cmp_d = adv;
        if (trunc_i) begin
            cmp_d = cmp_d & LOW_MASK;
            per_d = per_q & LOW_MASK;
        end
        if (any_wr) begin
            if (to_cmp) cmp_d = wval;
            else        per_d = wval;
        end
    end

    // Register the comparator (reset all ones) and the period (reset zero).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            cmp_q <= cmp_d;
            per_q <= per_d;
        end
    end

    assign cmp_o = cmp_q;
    assign per_o = per_q;
endmodule

// File: rtl/evt_chan_match.sv
// Counter/comparator match and registered one-cycle fire pulse.
// Assumes the counter moves between matches; a parked counter that equals
// the comparator keeps the match true.
module evt_chan_match
    import evt_chan_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             glb_en_i,
    input  chan_mode_t       mode_i,
    output logic             hit_o,
    output logic             fire_o
);
    logic eq_lo, eq_hi, fire_q;

    // Compare the halves separately so 32-bit mode can ignore the upper one.
    always_comb begin
        eq_lo = (count_i[DW-1:0] == cmp_i[DW-1:0]);
        eq_hi = (count_i[CNT_W-1:DW] == cmp_i[CNT_W-1:DW]);
        hit_o = mode_i.enable && glb_en_i && eq_lo && (eq_hi || mode_i.mode32);
    end

    // Register the match into the fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= hit_o;
    end

    assign fire_o = fire_q;
endmodule

// File: rtl/evt_timer_channel.sv
// Top of one comparator timer channel: configuration, comparator/period
// datapath, match logic and the read multiplexer.
// Assumes the global block selects this channel and issues one access per cycle.
module evt_timer_channel
    import evt_chan_pkg::*;
#(
    parameter int              CNT_W     = 64,
    parameter int              DW        = 32,
    parameter int              AW        = 5,
    parameter logic [DW-1:0]   ROUTE_CAP = 32'h0000_00FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             glb_en_i,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic [DW-1:0]    reg_rdata_o,
    output logic             fire_o
);
    logic [DW-1:0]    cfg_q;
    chan_mode_t       mode;
    logic             cmp_wr_lo, cmp_wr_hi, trunc;
    logic [CNT_W-1:0] cmp_q, per_q;
    logic             hit;

    evt_chan_cfg #(.DW(DW), .AW(AW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .sel_i(reg_sel_i), .wr_i(reg_wr_i),
        .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .cfg_o(cfg_q),
        .mode_o(mode), .cmp_wr_lo_o(cmp_wr_lo), .cmp_wr_hi_o(cmp_wr_hi),
        .trunc_o(trunc)
    );

    evt_chan_cmp #(.CNT_W(CNT_W), .DW(DW)) i_cmp (
        .clk(clk), .rst_n(rst_n), .wdata_i(reg_wdata_i),
        .cmp_wr_lo_i(cmp_wr_lo), .cmp_wr_hi_i(cmp_wr_hi), .trunc_i(trunc),
        .mode_i(mode), .hit_i(hit), .cmp_o(cmp_q), .per_o(per_q)
    );

    evt_chan_match #(.CNT_W(CNT_W), .DW(DW)) i_match (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .cmp_i(cmp_q),
        .glb_en_i(glb_en_i), .mode_i(mode), .hit_o(hit), .fire_o(fire_o)
    );

    // Return the word at the selected offset; zero when not selected.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_sel_i) begin
            case (reg_addr_i)
                OFS_CFG:    reg_rdata_o = cfg_q;
                OFS_CAP:    reg_rdata_o = ROUTE_CAP;
                OFS_CMP_LO: reg_rdata_o = cmp_q[DW-1:0];
                OFS_CMP_HI: reg_rdata_o = cmp_q[CNT_W-1:DW];
                OFS_ROUTE:  reg_rdata_o = '0;
                default:    reg_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_chan_chk.sv
// Assertion checker for evt_timer_channel, attached by bind below.
// Assumes one access per cycle and inputs stable around the clock edge.
module evt_chan_chk #(
    parameter int            CNT_W     = 64,
    parameter int            DW        = 32,
    parameter int            AW        = 5,
    parameter logic [DW-1:0] ROUTE_CAP = 32'h0000_00FF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             wr,
    input logic [AW-1:0]    addr,
    input logic             glb_en,
    input logic [DW-1:0]    rdata,
    input logic             fire,
    input logic [DW-1:0]    cfg,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] per
);
    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-DW){1'b0}}, {DW{1'b1}}};

    logic cmp_wr, any_wr, mapped;
    assign cmp_wr = sel && wr && (addr == 5'h08 || addr == 5'h0C);
    assign any_wr = sel && wr;
    assign mapped = (addr == 5'h00) || (addr == 5'h04) || (addr == 5'h08) || (addr == 5'h0C);

    AST_CAP_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[4] && !cfg[5]); // R2
    AST_CAP_WORD_RO: assert property (@(posedge clk) disable iff (!rst_n)
        sel && addr == 5'h04 |-> rdata == ROUTE_CAP); // R3
    AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmp_wr) |-> !cfg[6]); // R5
    AST_MODE32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[8] && $past(cfg[8]) |-> cmp[CNT_W-1:DW] == '0 && per[CNT_W-1:DW] == '0); // R6
    AST_FIRE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(glb_en && cfg[2])); // R7
    AST_PERIODIC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && $past(cfg[3]) && !$past(any_wr)
        |-> cmp == (($past(cmp) + $past(per)) & ($past(cfg[8]) ? LOW_MASK : '1))); // R8
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !$past(cfg[3]) && !$past(any_wr) |-> cmp == $past(cmp)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || !mapped) |-> rdata == '0); // R10
endmodule

bind evt_timer_channel evt_chan_chk #(
    .CNT_W(CNT_W), .DW(DW), .AW(AW), .ROUTE_CAP(ROUTE_CAP)
) i_chk (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel_i), .wr(reg_wr_i),
    .addr(reg_addr_i), .glb_en(glb_en_i), .rdata(reg_rdata_o),
    .fire(fire_o), .cfg(cfg_q), .cmp(cmp_q), .per(per_q)
);

// File: tb/test_evt_timer_channel.sv
`timescale 1ns/1ps
module test_evt_timer_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = 64'd0;
    logic        glb_en = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = 5'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        fire;

    int    errors = 0;
    int    checks = 0;
    int    fcount = 0;
    bit    cnt_run = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_cfg;
    logic [63:0] m_cmp, m_per;
    logic        m_fire;

    always #2 clk = ~clk;

    evt_timer_channel i_evt_timer_channel (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb_en),
        .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fire_o(fire)
    );

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        logic        hit, to_cmp;
        logic [31:0] n_cfg;
        logic [63:0] n_cmp, n_per, old, v;
        if (!rst_n) begin
            m_cfg = 32'h10; m_cmp = '1; m_per = '0; m_fire = 1'b0;
        end else begin
            hit = glb_en && m_cfg[2] &&
                  (m_cfg[8] ? (cnt[31:0] == m_cmp[31:0]) : (cnt == m_cmp));
            n_cfg = m_cfg; n_cmp = m_cmp; n_per = m_per;
            if (hit && m_cfg[3]) begin
                n_cmp = m_cmp + m_per;
                if (m_cfg[8]) n_cmp[63:32] = 32'h0;
            end
            if (sel && wr) begin
                if (addr == 5'h00) begin
                    n_cfg = (wdata & 32'h3F4E) | (m_cfg & ~32'h3F4E);
                    if (wdata[8]) begin n_cmp[63:32] = 32'h0; n_per[63:32] = 32'h0; end
                end else if (addr == 5'h08 || addr == 5'h0C) begin
                    to_cmp = !m_cfg[3] || m_cfg[6];
                    old = to_cmp ? m_cmp : m_per;
                    if (addr == 5'h08) v = {32'h0, wdata};
                    else v = {(m_cfg[8] ? 32'h0 : wdata), old[31:0]};
                    if (to_cmp) n_cmp = v; else n_per = v;
                    n_cfg[6] = 1'b0;
                end
            end
            m_cfg = n_cfg; m_cmp = n_cmp; m_per = n_per; m_fire = hit;
        end
    end

    function automatic logic [31:0] model_rd();
        if (!sel) return 32'h0;
        case (addr)
            5'h00: return m_cfg;
            5'h04: return 32'hFF;
            5'h08: return m_cmp[31:0];
            5'h0C: return m_cmp[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Compare outputs with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (fire !== m_fire) begin
                errors++;
                $display("FAIL %s/R7 fire_o: actual=%0b expected=%0b", cur_req, fire, m_fire);
            end
            checks++;
            if (rdata !== model_rd()) begin
                errors++;
                $display("FAIL %s rdata@%h: actual=%h expected=%h", cur_req, addr, rdata, model_rd());
            end
            if (fire === 1'b1) fcount++;
        end
    end

    task automatic cycle();
        @(negedge clk); #1;
        if (cnt_run) cnt = cnt + 64'd1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        cycle(); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        cycle(); wr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        cycle(); sel = 1'b1; wr = 1'b0; addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        chk("R1 fire_o", {31'h0, fire}, 32'h0);
        rd_chk("R1 cfg", 5'h00, 32'h10);
        rd_chk("R1 cap", 5'h04, 32'hFF);
        rd_chk("R1 cmp_lo", 5'h08, 32'hFFFF_FFFF);
        rd_chk("R1 cmp_hi", 5'h0C, 32'hFFFF_FFFF);
        // R2: write mask, R6 truncation on set
        cur_req = "R2";
        wr_reg(5'h00, 32'hFFFF_FFFF);
        rd_chk("R2 cfg mask", 5'h00, 32'h3F5E);
        rd_chk("R6 trunc cmp_hi", 5'h0C, 32'h0);
        wr_reg(5'h00, 32'h0);
        rd_chk("R2 cfg clear", 5'h00, 32'h10);
        // R3: capability read-only
        cur_req = "R3";
        wr_reg(5'h04, 32'h1234_5678);
        rd_chk("R3 cap", 5'h04, 32'hFF);
        rd_chk("R3 cfg untouched", 5'h00, 32'h10);
        // R10: route and unmapped offsets, unselected write
        cur_req = "R10";
        rd_chk("R10 route", 5'h10, 32'h0);
        rd_chk("R10 unmapped", 5'h14, 32'h0);
        cycle(); sel = 1'b0; wr = 1'b1; addr = 5'h00; wdata = 32'h4;
        cycle(); wr = 1'b0; #1;
        chk("R10 rdata unselected", rdata, 32'h0);
        rd_chk("R10 ignored write", 5'h00, 32'h10);
        // R9: one-shot fires once
        cur_req = "R9";
        glb_en = 1'b1;
        wr_reg(5'h08, 32'd20);
        wr_reg(5'h0C, 32'd0);
        wr_reg(5'h00, 32'h4);
        fcount = 0;
        cycle(); cnt = 64'd10; cnt_run = 1'b1;
        tick(20); cnt_run = 1'b0;
        tick(2);
        chk("R9 one-shot fires", fcount, 32'd1);
        rd_chk("R9 cmp held", 5'h08, 32'd20);
        // R7: global enable gates the fire
        cur_req = "R7";
        glb_en = 1'b0; fcount = 0;
        cycle(); cnt = 64'd10; cnt_run = 1'b1;
        tick(20); cnt_run = 1'b0;
        tick(2);
        chk("R7 no fire when global off", fcount, 32'd0);
        glb_en = 1'b1;
        // R4/R5: steering and set-value
        cur_req = "R4";
        wr_reg(5'h00, 32'h4C);
        rd_chk("R4 cfg periodic+setval", 5'h00, 32'h5C);
        wr_reg(5'h08, 32'd50);
        rd_chk("R5 setval cleared", 5'h00, 32'h1C);
        wr_reg(5'h08, 32'd10);
        rd_chk("R4 period write leaves cmp", 5'h08, 32'd50);
        // R8: periodic advance
        cur_req = "R8";
        fcount = 0;
        cycle(); cnt = 64'd40; cnt_run = 1'b1;
        tick(35); cnt_run = 1'b0;
        tick(2);
        chk("R8 periodic fire count", fcount, 32'd3);
        rd_chk("R8 cmp advanced", 5'h08, 32'd80);
        // R6: 32-bit mode
        cur_req = "R6";
        wr_reg(5'h00, 32'h04);
        wr_reg(5'h08, 32'h100);
        wr_reg(5'h0C, 32'h5);
        rd_chk("R4 hi write", 5'h0C, 32'h5);
        wr_reg(5'h00, 32'h104);
        rd_chk("R6 trunc hi", 5'h0C, 32'h0);
        rd_chk("R6 trunc lo kept", 5'h08, 32'h100);
        wr_reg(5'h0C, 32'h9);
        rd_chk("R6 hi write ignored", 5'h0C, 32'h0);
        fcount = 0;
        cycle(); cnt = 64'h7_0000_00F8; cnt_run = 1'b1;
        tick(16); cnt_run = 1'b0;
        tick(2);
        chk("R6 32-bit compare fires", fcount, 32'd1);
        tick(2);
        finish_run();
    end
endmodule